// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the byte-wide arithmetic and logic unit of a small 8-bit controller core. Each cycle it takes the accumulator, a second operand byte, the B register, the incoming carry, auxiliary-carry and overflow flags, and a 5-bit operation code. It returns the new accumulator byte, the new B byte, the three updated flags and the parity of the new accumulator. Operand fetch, register storage and instruction decode live elsewhere in the core.

The unit covers binary add and subtract (with and without carry or borrow), increment and decrement, the bytewise logic operations, the four rotates, nibble swap, unsigned multiply and divide on the A/B pair, and the decimal adjust that follows a BCD addition. Each operation class changes only the flags it owns and passes the other flags through unchanged, so the surrounding core can write the outputs back without masking. All outputs are registered, so results appear one clock after the inputs that produced them.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) returns A+operand mod 256; C is the carry out of bit 7 and AC is the carry out of bit 3, each cleared when there is none; the incoming C is not added.
- R2: Op code 1 (add with carry) adds the incoming C as well; op code 2 (subtract with borrow) returns A-operand-C mod 256, with C set when that borrows (A < operand+C) and AC set when the low nibbles borrow.
- R3: For op codes 0, 1 and 2, OV is set exactly when the signed two's-complement result overflows: operands of equal sign giving a result of the other sign for add, operands of different sign giving a result whose sign differs from A for subtract.
- R4: Op code 3 (increment) and op code 4 (decrement) wrap FFh to 00h and 00h to FFh, and return C, AC and OV equal to their incoming values.
- R5: Op codes 5, 6 and 7 return A AND, OR and XOR the operand; op code 8 returns the bitwise complement of A; all four return C, AC and OV unchanged.
- R6: Op code 9 rotates A left with bit 7 entering bit 0, op code 11 rotates right with bit 0 entering bit 7, both leaving all flags unchanged; op code 10 rotates left and op code 12 rotates right through C as a ninth bit, changing C only.
- R7: Op code 13 exchanges the two nibbles of A and leaves all flags unchanged.
- R8: Op code 14 multiplies A by B unsigned, returns the low product byte as the accumulator and the high byte as B, clears C, sets OV when the product exceeds FFh, and keeps AC.
- R9: Op code 15 divides A by B unsigned, returning the quotient as the accumulator and the remainder as B with C and OV cleared; when B is zero it returns A and B unchanged, sets OV and clears C; AC is kept.
- R10: Op code 16 (decimal adjust) adds 06h when the low nibble of A exceeds 9 or AC is set, then adds 60h when the resulting high nibble exceeds 9, C is set, or the first step carried; C becomes 1 if the corrected value exceeds FFh and otherwise keeps its incoming value; AC and OV are kept.
- R11: The parity output equals the XOR of all eight bits of the accumulator output.
- R12: All results are registered and appear one clock after their inputs; a synchronous active-high reset sets the accumulator, B and all flags to zero; every op code other than 14 and 15 returns B unchanged.
- R13: Op codes 17 to 31 return A, B and all three flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand byte |
| b_i | input | 8 | B register value |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming auxiliary-carry flag |
| ov_i | input | 1 | Incoming overflow flag |
| acc_o | output | 8 | Result accumulator byte |
| b_o | output | 8 | Result B byte |
| cy_o | output | 1 | Result carry flag |
| ac_o | output | 1 | Result auxiliary-carry flag |
| ov_o | output | 1 | Result overflow flag |
| par_o | output | 1 | Parity of acc_o |

## Verification
Every result of this block, the accumulator, B, the three flags and parity alike, is due exactly one rising edge after the operation code and operands are presented, since the only storage is the output register. The bench changes inputs on the falling edge and compares on the next falling edge, halfway after the edge that captures the result, and one directed check samples just after a change of inputs to show the old result still holds. The decimal-adjust sweep chains two operations, feeding the carry and auxiliary carry produced by an add back in as the inputs of the adjust one cycle later.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW = 8;
    localparam int NW = DW / 2;
    localparam int PW = 2 * DW;
    localparam logic [DW-1:0] ONE_W = DW'(1);
    localparam logic [NW-1:0] NIB_MAX = NW'(9);
    localparam logic [DW:0] FIX_LO = (DW + 1)'(6);
    localparam logic [DW:0] FIX_HI = (DW + 1)'(6 << NW);

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUBB = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_CPL  = 5'd8,
        OP_RL   = 5'd9,
        OP_RLC  = 5'd10,
        OP_RR   = 5'd11,
        OP_RRC  = 5'd12,
        OP_SWAP = 5'd13,
        OP_MUL  = 5'd14,
        OP_DIV  = 5'd15,
        OP_DA   = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        GRP_NONE,
        GRP_ARITH,
        GRP_BITS,
        GRP_MULDIV
    } alu_grp_e;

    typedef struct packed {
        logic c;
        logic ac;
        logic ov;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        flags_t        f;
    } alu_res_t;

    typedef struct packed {
        logic [DW-1:0] sum;
        flags_t        f;
    } addsub_t;

    // Which unit owns an operation code
    function automatic alu_grp_e op_group(logic [4:0] op);
        case (op)
            OP_ADD, OP_ADDC, OP_SUBB, OP_INC, OP_DEC, OP_DA: return GRP_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_CPL,
            OP_RL, OP_RLC, OP_RR, OP_RRC, OP_SWAP:           return GRP_BITS;
            OP_MUL, OP_DIV:                                  return GRP_MULDIV;
            default:                                         return GRP_NONE;
        endcase
    endfunction

    // Byte add or subtract with carry/borrow in, producing all three flags
    function automatic addsub_t add_sub(logic [DW-1:0] x, logic [DW-1:0] y,
                                        logic cin, logic sub);
        addsub_t       r;
        logic [DW:0]   full;
        logic [NW:0]   low;
        logic [DW:0]   cin_w;
        logic [NW:0]   cin_n;
        cin_w = {{DW{1'b0}}, cin};
        cin_n = {{NW{1'b0}}, cin};
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - cin_w;
            low  = {1'b0, x[NW-1:0]} - {1'b0, y[NW-1:0]} - cin_n;
            r.f.ov = (x[DW-1] != y[DW-1]) && (full[DW-1] != x[DW-1]);
        end else begin
            full = {1'b0, x} + {1'b0, y} + cin_w;
            low  = {1'b0, x[NW-1:0]} + {1'b0, y[NW-1:0]} + cin_n;
            r.f.ov = (x[DW-1] == y[DW-1]) && (full[DW-1] != x[DW-1]);
        end
        r.sum  = full[DW-1:0];
        r.f.c  = full[DW];
        r.f.ac = low[NW];
        return r;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  logic [4:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] d_i,
    input  logic [DW-1:0] b_i,
    input  flags_t        f_i,
    output alu_res_t      r_o
);

    addsub_t     as_r;
    logic        is_sub;
    logic        use_cin;
    logic        lo_fix;
    logic        hi_fix;
    logic [DW:0] da_t;
    logic [DW:0] da_s;

    assign is_sub  = (op_i == OP_SUBB);
    assign use_cin = (op_i == OP_ADDC) || (op_i == OP_SUBB);
    assign as_r    = add_sub(a_i, d_i, use_cin & f_i.c, is_sub);

    // Decimal adjust: two correction steps, carry of the first feeds the second
    always_comb begin
        lo_fix = (a_i[NW-1:0] > NIB_MAX) || f_i.ac;
        da_t   = {1'b0, a_i} + (lo_fix ? FIX_LO : '0);
        hi_fix = (da_t[DW-1:NW] > NIB_MAX) || f_i.c || da_t[DW];
        da_s   = da_t + (hi_fix ? FIX_HI : '0);
    end

    always_comb begin
        r_o.a = a_i;
        r_o.b = b_i;
        r_o.f = f_i;
        case (op_i)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                r_o.a = as_r.sum;
                r_o.f = as_r.f;
            end
            OP_INC:  r_o.a = a_i + ONE_W;
            OP_DEC:  r_o.a = a_i - ONE_W;
            OP_DA: begin
                r_o.a   = da_s[DW-1:0];
                r_o.f.c = f_i.c | da_s[DW];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  logic [4:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] d_i,
    input  logic [DW-1:0] b_i,
    input  flags_t        f_i,
    output alu_res_t      r_o
);

    always_comb begin
        r_o.a = a_i;
        r_o.b = b_i;
        r_o.f = f_i;
        case (op_i)
            OP_AND:  r_o.a = a_i & d_i;
            OP_OR:   r_o.a = a_i | d_i;
            OP_XOR:  r_o.a = a_i ^ d_i;
            OP_CPL:  r_o.a = ~a_i;
            OP_RL:   r_o.a = {a_i[DW-2:0], a_i[DW-1]};
            OP_RR:   r_o.a = {a_i[0], a_i[DW-1:1]};
            OP_RLC: begin
                r_o.a   = {a_i[DW-2:0], f_i.c};
                r_o.f.c = a_i[DW-1];
            end
            OP_RRC: begin
                r_o.a   = {f_i.c, a_i[DW-1:1]};
                r_o.f.c = a_i[0];
            end
            OP_SWAP: r_o.a = {a_i[NW-1:0], a_i[DW-1:NW]};
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv
    import alu8_pkg::*;
(
    input  logic [4:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  flags_t        f_i,
    output alu_res_t      r_o
);

    logic [PW-1:0] prod;
    logic [DW-1:0] quo;
    logic [DW-1:0] rem [DW+1];
    logic          div_zero;

    assign prod     = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
    assign div_zero = (b_i == '0);
    assign rem[0]   = '0;

    // Restoring divider: one compare-and-subtract row per quotient bit
    for (genvar k = 0; k < DW; k++) begin : g_div_row
        localparam int BIT = DW - 1 - k;
        logic [DW:0] trial;
        logic [DW:0] diff;
        logic        fits;
        assign trial      = {rem[k], a_i[BIT]};
        assign fits       = trial >= {1'b0, b_i};
        assign diff       = trial - {1'b0, b_i};
        assign quo[BIT]   = fits;
        assign rem[k + 1] = fits ? diff[DW-1:0] : trial[DW-1:0];
    end

    // Divider rows must reproduce the division identity for nonzero divisors
    always_comb begin
        if (!div_zero) begin
            p_div_identity_r9: assert ((({{DW{1'b0}}, quo} * {{DW{1'b0}}, b_i})
                                        + {{DW{1'b0}}, rem[DW]} == {{DW{1'b0}}, a_i})
                                       && (rem[DW] < b_i));
        end
    end

    always_comb begin
        r_o.a = a_i;
        r_o.b = b_i;
        r_o.f = f_i;
        case (op_i)
            OP_MUL: begin
                r_o.a    = prod[DW-1:0];
                r_o.b    = prod[PW-1:DW];
                r_o.f.c  = 1'b0;
                r_o.f.ov = |prod[PW-1:DW];
            end
            OP_DIV: begin
                r_o.f.c = 1'b0;
                if (div_zero) begin
                    r_o.f.ov = 1'b1;
                end else begin
                    r_o.a    = quo;
                    r_o.b    = rem[DW];
                    r_o.f.ov = 1'b0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] op_i,
    input  logic [7:0] acc_i,
    input  logic [7:0] opnd_i,
    input  logic [7:0] b_i,
    input  logic       cy_i,
    input  logic       ac_i,
    input  logic       ov_i,
    output logic [7:0] acc_o,
    output logic [7:0] b_o,
    output logic       cy_o,
    output logic       ac_o,
    output logic       ov_o,
    output logic       par_o
);

    flags_t   f_in;
    alu_res_t r_arith;
    alu_res_t r_bits;
    alu_res_t r_md;
    alu_res_t r_sel;
    alu_res_t r_q;
    logic     primed_q;

    assign f_in = '{c: cy_i, ac: ac_i, ov: ov_i};

    alu8_arith u_arith (
        .op_i (op_i),
        .a_i  (acc_i),
        .d_i  (opnd_i),
        .b_i  (b_i),
        .f_i  (f_in),
        .r_o  (r_arith)
    );

    alu8_bitops u_bits (
        .op_i (op_i),
        .a_i  (acc_i),
        .d_i  (opnd_i),
        .b_i  (b_i),
        .f_i  (f_in),
        .r_o  (r_bits)
    );

    alu8_muldiv u_md (
        .op_i (op_i),
        .a_i  (acc_i),
        .b_i  (b_i),
        .f_i  (f_in),
        .r_o  (r_md)
    );

    always_comb begin
        case (op_group(op_i))
            GRP_ARITH:  r_sel = r_arith;
            GRP_BITS:   r_sel = r_bits;
            GRP_MULDIV: r_sel = r_md;
            default:    r_sel = '{a: acc_i, b: b_i, f: f_in};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_sel;
        end
    end

    // Low for the first cycle after reset, when outputs still hold reset values
    always_ff @(posedge clk) begin
        primed_q <= ~rst;
    end

    assign acc_o = r_q.a;
    assign b_o   = r_q.b;
    assign cy_o  = r_q.f.c;
    assign ac_o  = r_q.f.ac;
    assign ov_o  = r_q.f.ov;
    assign par_o = ^r_q.a;

    p_reset_state_r12: assert property (@(posedge clk) disable iff (rst)
        !primed_q |-> (acc_o == 8'h00 && b_o == 8'h00 && !cy_o && !ac_o && !ov_o));

    p_incdec_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (primed_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
        |-> (cy_o == $past(cy_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i)));

    p_logic_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (primed_q && ($past(op_i) == OP_AND || $past(op_i) == OP_OR ||
                      $past(op_i) == OP_XOR || $past(op_i) == OP_CPL))
        |-> (cy_o == $past(cy_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i)
             && b_o == $past(b_i)));

    p_rot_noflag_r6: assert property (@(posedge clk) disable iff (rst)
        (primed_q && ($past(op_i) == OP_RL || $past(op_i) == OP_RR))
        |-> (cy_o == $past(cy_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i)
             && $countones(acc_o) == $countones($past(acc_i))));

    p_mul_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(op_i) == OP_MUL)
        |-> (!cy_o && ov_o == (b_o != 8'h00) && ac_o == $past(ac_i)));

    p_div_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(op_i) == OP_DIV && $past(b_i) == 8'h00)
        |-> (ov_o && !cy_o && acc_o == $past(acc_i) && b_o == 8'h00));

    p_bypass_r13: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(op_i) > OP_DA)
        |-> (acc_o == $past(acc_i) && b_o == $past(b_i) && cy_o == $past(cy_i)
             && ac_o == $past(ac_i) && ov_o == $past(ov_i)));

endmodule

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = 5'd0;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] opnd_i = 8'h00;
    logic [7:0] b_i = 8'h00;
    logic       cy_i = 1'b0;
    logic       ac_i = 1'b0;
    logic       ov_i = 1'b0;
    logic [7:0] acc_o;
    logic [7:0] b_o;
    logic       cy_o;
    logic       ac_o;
    logic       ov_o;
    logic       par_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    alu8_core uut (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op_i),
        .acc_i  (acc_i),
        .opnd_i (opnd_i),
        .b_i    (b_i),
        .cy_i   (cy_i),
        .ac_i   (ac_i),
        .ov_i   (ov_i),
        .acc_o  (acc_o),
        .b_o    (b_o),
        .cy_o   (cy_o),
        .ac_o   (ac_o),
        .ov_o   (ov_o),
        .par_o  (par_o)
    );

    // Vector: op, A, operand, B, flags in {c,ac,ov}, expected A, expected B, expected flags
    localparam int NV = 26;
    localparam logic [50:0] VEC [NV] = '{
        {5'd0,  8'h3A, 8'hC6, 8'h55, 3'b001, 8'h00, 8'h55, 3'b110}, // R1 carry out of both nibbles
        {5'd0,  8'h7F, 8'h01, 8'h00, 3'b100, 8'h80, 8'h00, 3'b011}, // R3 add overflow, C in ignored
        {5'd1,  8'h12, 8'h34, 8'h00, 3'b111, 8'h47, 8'h00, 3'b000}, // R2 add with carry
        {5'd1,  8'hFF, 8'h00, 8'h00, 3'b100, 8'h00, 8'h00, 3'b110}, // R2 carry ripples out
        {5'd2,  8'h50, 8'h20, 8'h00, 3'b100, 8'h2F, 8'h00, 3'b010}, // R2 borrow used, nibble borrow
        {5'd2,  8'h80, 8'h01, 8'h00, 3'b000, 8'h7F, 8'h00, 3'b011}, // R3 subtract overflow
        {5'd2,  8'h10, 8'h20, 8'h00, 3'b000, 8'hF0, 8'h00, 3'b100}, // R2 full borrow
        {5'd3,  8'hFF, 8'h00, 8'h00, 3'b101, 8'h00, 8'h00, 3'b101}, // R4 increment wraps
        {5'd4,  8'h00, 8'h00, 8'h00, 3'b010, 8'hFF, 8'h00, 3'b010}, // R4 decrement wraps
        {5'd5,  8'hF0, 8'h3C, 8'h00, 3'b111, 8'h30, 8'h00, 3'b111}, // R5 and
        {5'd6,  8'h0F, 8'h30, 8'h00, 3'b001, 8'h3F, 8'h00, 3'b001}, // R5 or
        {5'd7,  8'hAA, 8'hFF, 8'h00, 3'b100, 8'h55, 8'h00, 3'b100}, // R5 xor
        {5'd8,  8'h5A, 8'hFF, 8'h00, 3'b011, 8'hA5, 8'h00, 3'b011}, // R5 complement
        {5'd9,  8'h81, 8'h00, 8'h00, 3'b010, 8'h03, 8'h00, 3'b010}, // R6 rotate left
        {5'd10, 8'h81, 8'h00, 8'h00, 3'b001, 8'h02, 8'h00, 3'b101}, // R6 rotate left via C
        {5'd11, 8'h01, 8'h00, 8'h00, 3'b000, 8'h80, 8'h00, 3'b000}, // R6 rotate right
        {5'd12, 8'h02, 8'h00, 8'h00, 3'b110, 8'h81, 8'h00, 3'b010}, // R6 rotate right via C
        {5'd13, 8'h3C, 8'h00, 8'h00, 3'b111, 8'hC3, 8'h00, 3'b111}, // R7 swap
        {5'd14, 8'h50, 8'h00, 8'hA0, 3'b110, 8'h00, 8'h32, 3'b011}, // R8 wide product
        {5'd14, 8'h0F, 8'h00, 8'h11, 3'b101, 8'hFF, 8'h00, 3'b000}, // R8 product fits
        {5'd15, 8'hFB, 8'h00, 8'h12, 3'b111, 8'h0D, 8'h11, 3'b010}, // R9 divide
        {5'd15, 8'h77, 8'h00, 8'h00, 3'b000, 8'h77, 8'h00, 3'b001}, // R9 divide by zero
        {5'd16, 8'h41, 8'h00, 8'h00, 3'b011, 8'h47, 8'h00, 3'b011}, // R10 low fix from AC
        {5'd16, 8'h9A, 8'h00, 8'h00, 3'b000, 8'h00, 8'h00, 3'b100}, // R10 both fixes, carry out
        {5'd16, 8'h12, 8'h00, 8'h00, 3'b100, 8'h72, 8'h00, 3'b100}, // R10 high fix from C
        {5'd20, 8'h5C, 8'hAA, 8'h09, 3'b101, 8'h5C, 8'h09, 3'b101}  // R13 unused code
    };
    localparam int VREQ [NV] = '{1, 3, 2, 2, 2, 3, 2, 4, 4, 5, 5, 5, 5,
                                 6, 6, 6, 6, 7, 8, 8, 9, 9, 10, 10, 10, 13};

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Present inputs on a falling edge, return on the next falling edge
    task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] d,
                         input logic [7:0] b, input logic [2:0] fl);
        @(negedge clk);
        op_i   = op;
        acc_i  = a;
        opnd_i = d;
        b_i    = b;
        {cy_i, ac_i, ov_i} = fl;
        @(negedge clk);
    endtask

    task automatic chk_all(input string req, input logic [7:0] ea, input logic [7:0] eb,
                           input logic [2:0] ef);
        chk(req, "acc", {8'h00, acc_o}, {8'h00, ea});
        chk(req, "b", {8'h00, b_o}, {8'h00, eb});
        chk(req, "flags", {13'h0, cy_o, ac_o, ov_o}, {13'h0, ef});
        chk("R11", "parity", {15'h0, par_o}, {15'h0, ^ea});
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R12 reset state, with nonzero inputs applied during reset
        op_i = 5'd0; acc_i = 8'hFF; opnd_i = 8'hFF; b_i = 8'hEE; {cy_i, ac_i, ov_i} = 3'b111;
        repeat (3) @(negedge clk);
        chk_all("R12", 8'h00, 8'h00, 3'b000);
        rst = 1'b0;

        // Table of vectors
        for (int i = 0; i < NV; i++) begin
            logic [50:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d", VREQ[i]);
            drive(v[50:46], v[45:38], v[37:30], v[29:22], v[21:19]);
            chk_all(tag, v[18:11], v[10:3], v[2:0]);
        end

        // R12 latency: result holds until the next rising edge
        drive(5'd3, 8'h10, 8'h00, 8'h00, 3'b000);
        chk("R12", "inc before change", {8'h00, acc_o}, 16'h0011);
        op_i = 5'd4; acc_i = 8'h40;
        #1;
        chk("R12", "old result held", {8'h00, acc_o}, 16'h0011);
        @(negedge clk);
        chk("R12", "new result after edge", {8'h00, acc_o}, 16'h003F);

        // R12 B passes through for a non-multiply op
        drive(5'd0, 8'h01, 8'h01, 8'hC7, 3'b000);
        chk("R12", "b pass on add", {8'h00, b_o}, 16'h00C7);

        // R8 and R9 sweep over operand pairs
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 23) begin
                int p;
                p = a * b;
                drive(5'd14, 8'(a), 8'h00, 8'(b), 3'b110);
                chk_all("R8", 8'(p % 256), 8'(p / 256), {1'b0, 1'b1, (p > 255)});
                if (b == 0) begin
                    drive(5'd15, 8'(a), 8'h00, 8'h00, 3'b101);
                    chk_all("R9", 8'(a), 8'h00, 3'b001);
                end else begin
                    drive(5'd15, 8'(a), 8'h00, 8'(b), 3'b101);
                    chk_all("R9", 8'(a / b), 8'(a % b), 3'b000);
                end
            end
        end

        // R10 BCD add followed by adjust, flags of the add fed to the adjust
        for (int x = 0; x < 100; x += 7) begin
            for (int y = 0; y < 100; y += 13) begin
                logic [7:0] sum_a;
                logic       c_add;
                logic       ac_add;
                int         s;
                s = x + y;
                drive(5'd0, to_bcd(x), to_bcd(y), 8'h00, 3'b000);
                sum_a = acc_o; c_add = cy_o; ac_add = ac_o;
                drive(5'd16, sum_a, 8'h00, 8'h00, {c_add, ac_add, 1'b0});
                chk("R10", "bcd digits", {8'h00, acc_o}, {8'h00, to_bcd(s % 100)});
                chk("R10", "bcd carry", {15'h0, cy_o}, {15'h0, (s >= 100)});
            end
        end

        // R12 reset again after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_all("R12", 8'h00, 8'h00, 3'b000);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule